// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges the reset requests of a chip into one system reset line that always stays low for a guaranteed minimum number of clock cycles. It runs on a free-running always-on clock. The sources are power-on, an external reset pin, an independent watchdog, a window watchdog, a software request, an option-load request, and two low-power-entry requests: standby and deep-sleep. Every source is active low. Each low-power-entry request produces a reset only when its active-low option enable is cleared. The external pin goes through a glitch filter. The other asynchronous requests assert at once and release through a two-flop synchronizer.

A three-state machine stretches the merged request. `ST_ASSERT` holds the reset while any request is present and moves to `ST_STRETCH` once all requests are gone. `ST_STRETCH` counts `PULSE_CYC` cycles. It returns to `ST_ASSERT` if a new request arrives, which restarts the count, and it moves to `ST_RUN` when the count expires. `ST_RUN` releases the reset and moves back to `ST_ASSERT` on any request. Power-on reset places the machine in `ST_ASSERT`.

A sticky cause register records which sources fired, and software clears it by writing ones. A separate backup-domain reset follows its own control bit and the backup power-good inputs. The system reset never touches the backup-domain reset, so the backup domain and the debug port logic that lives outside this reset survive a system reset.

Top module: `sysrst_hub`

## Requirements
- R1: While `por_n` is low, `sys_rst_n` is low and `cause` equals 8'h01 (only the power bit is set). After `por_n` rises, `sys_rst_n` stays low for at least `PULSE_CYC` cycles.
- R2: A low level on `iwdt_n`, `wwdt_n`, `soft_n` or `optload_n` drives `sys_rst_n` low without waiting for a clock edge. After the request releases, `sys_rst_n` stays low for at least `PULSE_CYC` and at most `PULSE_CYC+4` further cycles.
- R3: A new request that arrives while the pulse is being stretched restarts the count, so `sys_rst_n` stays low for at least `PULSE_CYC` cycles after the last request releases.
- R4: A low pulse on `pin_n` that lasts at most `FILT_CYC-2` cycles causes no reset and sets no flag. A low pulse of `FILT_CYC+3` cycles causes a reset that lasts at least `PULSE_CYC` cycles.
- R5: `stby_enter` produces a reset only while `opt_stby_rst_n` is 0, and `dslp_enter` produces a reset only while `opt_dslp_rst_n` is 0. While the option bit is 1, entry causes no reset and sets no flag.
- R6: `cause` bit positions: 0 power, 1 pin, 2 independent watchdog, 3 window watchdog, 4 software, 5 option load, 6 standby, 7 deep-sleep. A bit is set by its request and stays set until it is cleared.
- R7: A one in `flag_clr` clears the matching `cause` bit on the next edge. If that source is still requesting, the set wins and the bit stays 1.
- R8: `bkp_rst_n` is low while `bkp_rst_ctl` is 1 and is released within 3 cycles after the bit clears. It is not stretched, and it changes neither `sys_rst_n` nor `cause`.
- R9: `bkp_rst_n` is low while both `vdd_ok` and `vbat_ok` are low, and is released within 3 cycles after either one returns.
- R10: A system reset from any source leaves `bkp_rst_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ao | input | 1 | Free-running always-on clock |
| por_n | input | 1 | Power-on reset, active low; also resets the block |
| pin_n | input | 1 | Raw external reset pin, active low |
| iwdt_n | input | 1 | Independent watchdog request, active low |
| wwdt_n | input | 1 | Window watchdog request, active low |
| soft_n | input | 1 | Software reset request, active low |
| optload_n | input | 1 | Option-load reset request, active low |
| stby_enter | input | 1 | Standby entry event, active high |
| dslp_enter | input | 1 | Deep-sleep entry event, active high |
| opt_stby_rst_n | input | 1 | Standby-entry reset enable, active low |
| opt_dslp_rst_n | input | 1 | Deep-sleep-entry reset enable, active low |
| bkp_rst_ctl | input | 1 | Backup-domain reset control bit |
| vdd_ok | input | 1 | Main supply good |
| vbat_ok | input | 1 | Battery supply good |
| flag_clr | input | 8 | Write-one-to-clear strobe for `cause` |
| sys_rst_n | output | 1 | Stretched system reset, active low |
| bkp_rst_n | output | 1 | Backup-domain reset, active low |
| cause | output | 8 | Sticky reset-cause flags |

## Verification
The bench targets restarts in the middle of a stretch. A design that kept counting would release the reset too early after the second request. It drives pin pulses just under and just over the filter length. A filter that is off by a few cycles would either pass glitches as resets or swallow real ones. It fires low-power entries with the option bit set and then cleared. Wrong gating would show up as a reset or flag that should not appear, or a missing one. It also clears a flag while its source is still requesting, where clear-over-set logic would lose the cause. Finally, it checks that the backup reset stays out of system resets and is released within 3 cycles. A shared stretcher would hold the backup reset for a full pulse.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
    localparam int N_CAUSE     = 8;
    localparam int C_POWER     = 0;
    localparam int C_PIN       = 1;
    localparam int C_INDEP_WDT = 2;
    localparam int C_WIN_WDT   = 3;
    localparam int C_SOFT      = 4;
    localparam int C_OPTLOAD   = 5;
    localparam int C_STANDBY   = 6;
    localparam int C_DEEPSLEEP = 7;

    typedef enum logic [1:0] {
        ST_ASSERT  = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } stretch_state_e;
endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rel_n
);
    // Assert at once, release after STAGES edges.
    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) shift_q <= '0;
        else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end

    assign rel_n = shift_q[STAGES-1];
endmodule

// File: rtl/sysrst_pinfilt.sv
module sysrst_pinfilt #(
    parameter int FILT_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic req_n
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(FILT_CYC);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    logic [CW-1:0]          run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end
    assign pin_s = sync_q[SYNC_STAGES-1];

    // Count consecutive low samples, saturate at FULL.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            run_q <= '0;
        else if (pin_s)        run_q <= '0;
        else if (run_q != FULL) run_q <= run_q + 1'b1;
    end

    assign req_n = (run_q != FULL);

    assert_filter_needs_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_n) |-> $past(!pin_s));
    assert_filter_drops_on_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pin_s |=> req_n);
endmodule

// File: rtl/sysrst_stretch.sv
module sysrst_stretch
    import sysrst_pkg::*;
#(
    parameter int PULSE_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_any,
    output logic sys_rst_n
);
    localparam int CW = $clog2(PULSE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] SAT  = CW'(PULSE_CYC);

    stretch_state_e state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_ASSERT: begin
                cnt_d = '0;
                if (!req_any) state_d = ST_STRETCH;
            end
            ST_STRETCH: begin
                if (req_any) begin
                    state_d = ST_ASSERT;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                cnt_d = '0;
                if (req_any) state_d = ST_ASSERT;
            end
            default: begin
                state_d = ST_ASSERT;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ASSERT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        sys_rst_n = (state_q == ST_RUN) && !req_any;
    end

    // Checker: length of the current low run, saturating.
    logic [CW-1:0] low_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              low_run_q <= '0;
        else if (sys_rst_n)      low_run_q <= '0;
        else if (low_run_q != SAT) low_run_q <= low_run_q + 1'b1;
    end

    assert_min_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> (low_run_q >= LAST));
    assert_no_release_on_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_any |=> (state_q != ST_RUN));
endmodule

// File: rtl/sysrst_flags.sv
module sysrst_flags
    import sysrst_pkg::*;
#(
    parameter int N = N_CAUSE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rq_n,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    localparam logic [N-1:0] POR_VAL = N'(1) << C_POWER;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= POR_VAL;
        else        flags <= (flags & ~clr) | ~rq_n;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_flag_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !rq_n[i] |=> flags[i]);
        assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && clr[i] && rq_n[i]) |=> !flags[i]);
    end
endmodule

// File: rtl/sysrst_hub.sv
module sysrst_hub
    import sysrst_pkg::*;
#(
    parameter int PULSE_CYC   = 2000,
    parameter int FILT_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_ao,
    input  logic               por_n,
    input  logic               pin_n,
    input  logic               iwdt_n,
    input  logic               wwdt_n,
    input  logic               soft_n,
    input  logic               optload_n,
    input  logic               stby_enter,
    input  logic               dslp_enter,
    input  logic               opt_stby_rst_n,
    input  logic               opt_dslp_rst_n,
    input  logic               bkp_rst_ctl,
    input  logic               vdd_ok,
    input  logic               vbat_ok,
    input  logic [N_CAUSE-1:0] flag_clr,
    output logic               sys_rst_n,
    output logic               bkp_rst_n,
    output logic [N_CAUSE-1:0] cause
);
    logic               pin_req_n;
    logic [N_CAUSE-1:0] raw_n;
    logic [N_CAUSE-1:0] rq_n;
    logic               req_any;
    logic               bkp_kill_n;

    sysrst_pinfilt #(.FILT_CYC(FILT_CYC), .SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk(clk_ao), .rst_n(por_n), .pin_n(pin_n), .req_n(pin_req_n)
    );

    always_comb begin
        raw_n[C_POWER]     = por_n;
        raw_n[C_PIN]       = pin_req_n;
        raw_n[C_INDEP_WDT] = iwdt_n;
        raw_n[C_WIN_WDT]   = wwdt_n;
        raw_n[C_SOFT]      = soft_n;
        raw_n[C_OPTLOAD]   = optload_n;
        raw_n[C_STANDBY]   = ~(stby_enter & ~opt_stby_rst_n);
        raw_n[C_DEEPSLEEP] = ~(dslp_enter & ~opt_dslp_rst_n);
    end

    // The filtered pin is already synchronous; the rest are synchronized on release.
    for (genvar i = 0; i < N_CAUSE; i++) begin : g_src
        if (i == C_PIN) begin : g_direct
            assign rq_n[i] = raw_n[i];
        end else begin : g_sync
            sysrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk(clk_ao), .arst_n(raw_n[i]), .rel_n(rq_n[i])
            );
        end
    end

    assign req_any = ~&rq_n;

    sysrst_stretch #(.PULSE_CYC(PULSE_CYC)) u_stretch (
        .clk(clk_ao), .rst_n(por_n), .req_any(req_any), .sys_rst_n(sys_rst_n)
    );

    sysrst_flags #(.N(N_CAUSE)) u_flags (
        .clk(clk_ao), .rst_n(por_n), .rq_n(rq_n), .clr(flag_clr), .flags(cause)
    );

    // Backup domain: own triggers, own synchronizer, no stretch.
    assign bkp_kill_n = ~bkp_rst_ctl & (vdd_ok | vbat_ok);

    sysrst_sync #(.STAGES(SYNC_STAGES)) u_bkp (
        .clk(clk_ao), .arst_n(bkp_kill_n), .rel_n(bkp_rst_n)
    );

    assert_por_holds_R1: assert property (@(posedge clk_ao)
        !por_n |-> !sys_rst_n);
    assert_bkp_ctl_holds_R8: assert property (@(posedge clk_ao)
        bkp_rst_ctl |-> !bkp_rst_n);
    assert_bkp_power_off_R9: assert property (@(posedge clk_ao)
        (!vdd_ok && !vbat_ok) |-> !bkp_rst_n);
endmodule

// File: tb/sysrst_hub_test.sv
module sysrst_hub_test;
    localparam int PULSE = 32;
    localparam int FILT  = 6;

    logic       clk_ao = 1'b0;
    logic       por_n = 1'b0, pin_n = 1'b1, iwdt_n = 1'b1, wwdt_n = 1'b1;
    logic       soft_n = 1'b1, optload_n = 1'b1, stby_enter = 1'b0, dslp_enter = 1'b0;
    logic       opt_stby_rst_n = 1'b1, opt_dslp_rst_n = 1'b1, bkp_rst_ctl = 1'b0;
    logic       vdd_ok = 1'b1, vbat_ok = 1'b1;
    logic [7:0] flag_clr = 8'h00;
    logic       sys_rst_n, bkp_rst_n;
    logic [7:0] cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk_ao = ~clk_ao;

    sysrst_hub #(.PULSE_CYC(PULSE), .FILT_CYC(FILT), .SYNC_STAGES(2)) uut (
        .clk_ao(clk_ao), .por_n(por_n), .pin_n(pin_n), .iwdt_n(iwdt_n), .wwdt_n(wwdt_n),
        .soft_n(soft_n), .optload_n(optload_n), .stby_enter(stby_enter),
        .dslp_enter(dslp_enter), .opt_stby_rst_n(opt_stby_rst_n),
        .opt_dslp_rst_n(opt_dslp_rst_n), .bkp_rst_ctl(bkp_rst_ctl), .vdd_ok(vdd_ok),
        .vbat_ok(vbat_ok), .flag_clr(flag_clr), .sys_rst_n(sys_rst_n),
        .bkp_rst_n(bkp_rst_n), .cause(cause)
    );

    function automatic logic [7:0] bit_of(input int idx);
        return 8'(1) << idx;
    endfunction

    function automatic int low_min(input int len);
        return len + PULSE;
    endfunction

    function automatic int low_max(input int len);
        return len + PULSE + 4;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int idx, input logic act);
        case (idx)
            1: pin_n      = ~act;
            2: iwdt_n     = ~act;
            3: wwdt_n     = ~act;
            4: soft_n     = ~act;
            5: optload_n  = ~act;
            6: stby_enter = act;
            7: dslp_enter = act;
            default: ;
        endcase
    endtask

    // Drive a request for len cycles; count negedges with sys_rst_n low until it rises.
    task automatic pulse_measure(input int idx, input int len, output int lowc, output bit bkp_seen_low);
        int cyc = 0;
        lowc = 0;
        bkp_seen_low = 1'b0;
        @(negedge clk_ao);
        drive(idx, 1'b1);
        forever begin
            @(negedge clk_ao);
            cyc++;
            if (cyc == len) drive(idx, 1'b0);
            if (cyc > len && sys_rst_n) break;
            if (!sys_rst_n) lowc++;
            if (!bkp_rst_n) bkp_seen_low = 1'b1;
            if (cyc > 3000) break;
        end
    endtask

    task automatic quiet(input int n, output int lowc);
        lowc = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk_ao);
            if (!sys_rst_n) lowc++;
        end
    endtask

    task automatic clear_flags(input logic [7:0] m);
        @(negedge clk_ao);
        flag_clr = m;
        @(negedge clk_ao);
        flag_clr = 8'h00;
    endtask

    initial begin
        int lowc;
        bit bl;
        int r;
        r = $urandom(32'd20240611);

        // R1: reset state during power-on
        repeat (3) @(negedge clk_ao);
        check(sys_rst_n == 1'b0, "R1 sys low in por", sys_rst_n, 0);
        check(cause == 8'h01, "R1 cause in por", cause, 8'h01);
        check(bkp_rst_n == 1'b1, "R10 bkp untouched by por", bkp_rst_n, 1);
        por_n = 1'b1;
        lowc = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk_ao);
            if (sys_rst_n) break;
            lowc++;
        end
        check(lowc >= PULSE, "R1 stretch after por", lowc, PULSE);
        check(cause == 8'h01, "R6 power flag", cause, 8'h01);
        clear_flags(8'hFF);
        check(cause == 8'h00, "R7 clear all", cause, 0);

        // R2/R6: each internal source
        for (int idx = 2; idx <= 5; idx++) begin
            pulse_measure(idx, 3, lowc, bl);
            check(lowc >= low_min(3) && lowc <= low_max(3), "R2 pulse width", lowc, low_min(3));
            check(cause == bit_of(idx), "R6 cause bit", cause, bit_of(idx));
            check(!bl, "R10 bkp stays high", bl, 0);
            clear_flags(8'hFF);
        end

        // R3: restart during stretch
        begin
            int cyc = 0;
            int second = 2 + PULSE / 2;
            lowc = 0;
            @(negedge clk_ao);
            drive(4, 1'b1);
            forever begin
                @(negedge clk_ao);
                cyc++;
                if (cyc == 2) drive(4, 1'b0);
                if (cyc == second) drive(3, 1'b1);
                if (cyc == second + 2) drive(3, 1'b0);
                if (cyc > second + 2 && sys_rst_n) break;
                if (!sys_rst_n) lowc++;
                if (cyc > 3000) break;
            end
            check(lowc >= second + 2 + PULSE, "R3 restart", lowc, second + 2 + PULSE);
            check(cause == (bit_of(3) | bit_of(4)), "R3 both causes", cause, bit_of(3) | bit_of(4));
            clear_flags(8'hFF);
        end

        // R4: pin filter
        pulse_measure(1, FILT - 2, lowc, bl);
        quiet(10, r);
        check(lowc + r == 0, "R4 glitch rejected", lowc + r, 0);
        check(cause == 8'h00, "R4 no flag on glitch", cause, 0);
        pulse_measure(1, FILT + 3, lowc, bl);
        check(lowc >= PULSE, "R4 long pin resets", lowc, PULSE);
        check(cause == bit_of(1), "R4 pin flag", cause, bit_of(1));
        clear_flags(8'hFF);

        // R5: option gating
        for (int idx = 6; idx <= 7; idx++) begin
            opt_stby_rst_n = 1'b1;
            opt_dslp_rst_n = 1'b1;
            pulse_measure(idx, 4, lowc, bl);
            quiet(10, r);
            check(lowc + r == 0, "R5 gated entry no reset", lowc + r, 0);
            check(cause == 8'h00, "R5 gated entry no flag", cause, 0);
            opt_stby_rst_n = 1'b0;
            opt_dslp_rst_n = 1'b0;
            pulse_measure(idx, 4, lowc, bl);
            check(lowc >= low_min(4) && lowc <= low_max(4), "R5 enabled entry resets", lowc, low_min(4));
            check(cause == bit_of(idx), "R5 entry flag", cause, bit_of(idx));
            clear_flags(8'hFF);
        end
        opt_stby_rst_n = 1'b1;
        opt_dslp_rst_n = 1'b1;

        // R7: set wins over clear
        @(negedge clk_ao);
        soft_n = 1'b0;
        repeat (2) @(negedge clk_ao);
        clear_flags(bit_of(4));
        check(cause[4] == 1'b1, "R7 set wins", cause[4], 1);
        soft_n = 1'b1;
        repeat (PULSE + 8) @(negedge clk_ao);
        clear_flags(bit_of(4));
        check(cause == 8'h00, "R7 clear after release", cause, 0);

        // R8: backup control bit
        @(negedge clk_ao);
        bkp_rst_ctl = 1'b1;
        @(negedge clk_ao);
        check(bkp_rst_n == 1'b0, "R8 bkp asserted", bkp_rst_n, 0);
        quiet(10, r);
        check(r == 0, "R8 sys untouched", r, 0);
        check(bkp_rst_n == 1'b0 && cause == 8'h00, "R8 held, no flag", {cause, bkp_rst_n}, 0);
        bkp_rst_ctl = 1'b0;
        repeat (3) @(negedge clk_ao);
        check(bkp_rst_n == 1'b1, "R8 bkp released fast", bkp_rst_n, 1);

        // R9: backup power
        vdd_ok = 1'b0;
        vbat_ok = 1'b0;
        @(negedge clk_ao);
        check(bkp_rst_n == 1'b0, "R9 bkp on power loss", bkp_rst_n, 0);
        vbat_ok = 1'b1;
        repeat (3) @(negedge clk_ao);
        check(bkp_rst_n == 1'b1, "R9 bkp release", bkp_rst_n, 1);
        vdd_ok = 1'b1;

        // Random requests against the model
        for (int it = 0; it < 20; it++) begin
            int idx = 2 + int'($urandom() % 4);
            int len = 1 + int'($urandom() % 10);
            logic [7:0] m = 8'($urandom());
            pulse_measure(idx, len, lowc, bl);
            check(lowc >= low_min(len) && lowc <= low_max(len), "R2 random width", lowc, low_min(len));
            check(!bl, "R10 random bkp", bl, 0);
            clear_flags(m);
            check(cause == (bit_of(idx) & ~m), "R7 random clear", cause, bit_of(idx) & ~m);
            clear_flags(8'hFF);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_ao);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule